// File: doc/BRIEF.md
# Cascaded Programmable Interrupt Controller

This block gathers sixteen interrupt request lines, numbered 0 to 15, and presents them to a processor as a single request with an 8-bit vector. It is built from two identical eight-line units. Line 2 of the primary unit does not come from a device. It carries the secondary unit's request, so lines 8 to 15 reach the processor through that slot. Each unit has a programmable vector base, which lets software move the sixteen lines onto any aligned block of vectors, for example 32 to 47, away from the processor's exception numbers.

Software reaches each unit through two byte-wide ports, a command port and a data port, using a one-cycle register write and register read interface. An initialisation word on the command port starts programming. The next data write sets the vector base. A fixed number of further data writes is then consumed and discarded. After that, data writes load the mask. When the processor acknowledges a request, the winning line moves from pending to in-service. The unit delivers nothing more until software writes an end-of-interrupt command to it.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset `cpu_irq` is low, both masks read 0xFF, both pending registers read 0x00, and no line is delivered until its unit has been initialised.
- R2: A command write with bit 4 set starts initialisation. The next data write to that unit sets its vector base to bits 7..3 of the written byte. While `cpu_irq` is high, `cpu_vector` is base + line for lines 0-7 (primary base) and base + (line-8) for lines 8-15 (secondary base).
- R3: Initialisation clears the unit's mask, pending and in-service bits, so after both units are set up, line 0 (interval timer) and line 1 (keyboard) are delivered without any mask write.
- R4: After the base word, further data writes are discarded as initialisation words: two of them if bit 0 of the initialisation word was 1, one if it was 0. The data write after those loads the mask.
- R5: A rising edge on a request line sets its pending bit. A line that stays high raises exactly one request.
- R6: A set mask bit (bit n of the unit's mask blocks that unit's line n) stops delivery. The pending bit is kept and is delivered once the bit is cleared.
- R7: Among unmasked pending lines the lowest number wins, and lines 8-15 compete at the priority of primary line 2. Input bit 2 is the cascade slot and raises no request of its own.
- R8: `cpu_ack` while `cpu_irq` is high moves the winner to in-service. `cpu_irq` then drops in the next cycle and stays low, while new edges remain pending, until a command write with bit 5 = 1, bit 4 = 0 and bit 3 = 0 (end-of-interrupt) clears the unit's lowest in-service bit.
- R9: A delivered line 8-15 needs end-of-interrupt on both units. With only the secondary cleared, no request is delivered through primary line 2.
- R10: Setting primary mask bit 2 blocks all of lines 8-15 while primary lines stay deliverable.
- R11: A rising edge on a line in the same cycle as its own acknowledge leaves that line pending, and it is delivered again after end-of-interrupt.
- R12: `cpu_ack` while `cpu_irq` is low changes no pending or in-service state.
- R13: With `reg_rd` high, `reg_rdata` shows the selected unit's mask on the data port (`reg_sel` = 1) and its pending bits on the command port (`reg_sel` = 0). It is 0x00 when `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read enable |
| reg_unit | input | 1 | Unit select: 0 primary, 1 secondary |
| reg_sel | input | 1 | Port select: 0 command, 1 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_lines | input | 16 | Request lines 0 to 15 |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vector | output | 8 | Vector of the winning line, valid while `cpu_irq` is high |
| cpu_ack | input | 1 | Acknowledge from the processor |

## Verification
Two things can happen in the same clock edge. One is the processor's acknowledge, which clears a pending bit. The other is a new rising edge on that same line, which sets it. The bench turns off its automatic acknowledge, waits for the request, and then drives `cpu_ack` and raises the just-served line at the same falling edge. It judges the outcome in two ways: the pending register read back through the command port must still show the line, and after end-of-interrupt the same vector must be offered again. The cascade ordering is also exercised. End-of-interrupt reaches the secondary before the primary, and the bench expects silence until the second command arrives.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int LINES_PER_UNIT = 8;
  localparam int IDX_W          = $clog2(LINES_PER_UNIT);
  localparam int VEC_W          = 8;
  localparam int BASE_W         = VEC_W - IDX_W;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_BASE  = 2'd1,
    PH_EXTRA = 2'd2
  } init_phase_t;

  // command word decoding
  function automatic logic is_init_word(input logic [7:0] w);
    return w[4];
  endfunction

  function automatic logic is_eoi_word(input logic [7:0] w);
    return w[5] && !w[4] && !w[3];
  endfunction

  function automatic logic [1:0] extra_words(input logic [7:0] w);
    return w[0] ? 2'd2 : 2'd1;
  endfunction

  // index of the lowest set bit (0 when none is set)
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [LINES_PER_UNIT-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINES_PER_UNIT - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // clear the lowest set bit
  function automatic logic [LINES_PER_UNIT-1:0] drop_lowest(input logic [LINES_PER_UNIT-1:0] v);
    return v & (v - LINES_PER_UNIT'(1));
  endfunction

  function automatic logic [VEC_W-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                   input logic [IDX_W-1:0]  idx);
    return {base, idx};
  endfunction

endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  assign rise = lines & ~prev_q;

endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter logic [LINES_PER_UNIT-1:0] LEVEL_LINES = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_we,
  input  logic                      data_we,
  input  logic [7:0]                wdata,
  input  logic [LINES_PER_UNIT-1:0] rise,
  input  logic [LINES_PER_UNIT-1:0] lvl,
  input  logic                      take,
  output logic                      want,
  output logic [IDX_W-1:0]          pick,
  output logic [VEC_W-1:0]          vec,
  output logic [LINES_PER_UNIT-1:0] mask_q,
  output logic [LINES_PER_UNIT-1:0] pend_q,
  output logic [LINES_PER_UNIT-1:0] serv_q,
  output logic                      init_evt,
  output logic                      eoi_evt
);

  init_phase_t               phase_q;
  logic [1:0]                extra_q;
  logic [BASE_W-1:0]         base_q;
  logic [LINES_PER_UNIT-1:0] elig;
  logic [LINES_PER_UNIT-1:0] pend_next;
  logic [LINES_PER_UNIT-1:0] serv_next;
  logic                      take_ok;

  assign init_evt = cmd_we && is_init_word(wdata);
  assign eoi_evt  = cmd_we && !is_init_word(wdata) && (phase_q == PH_RUN) && is_eoi_word(wdata);

  // level-fed slots (cascade) join the edge-latched pending bits
  assign elig    = (pend_q | (lvl & LEVEL_LINES)) & ~mask_q;
  assign want    = (phase_q == PH_RUN) && (serv_q == '0) && (|elig);
  assign pick    = lowest_idx(elig);
  assign vec     = make_vector(base_q, pick);
  assign take_ok = take && want;

  always_comb begin
    pend_next = pend_q;
    if (take_ok) pend_next[pick] = 1'b0;
    pend_next = pend_next | (rise & ~LEVEL_LINES);
  end

  always_comb begin
    serv_next = serv_q;
    if (eoi_evt) serv_next = drop_lowest(serv_q);
    if (take_ok) serv_next[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      extra_q <= '0;
      base_q  <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
      serv_q  <= '0;
    end else if (init_evt) begin
      phase_q <= PH_BASE;
      extra_q <= extra_words(wdata);
      mask_q  <= '0;
      pend_q  <= '0;
      serv_q  <= '0;
    end else begin
      pend_q <= pend_next;
      serv_q <= serv_next;
      if (data_we) begin
        case (phase_q)
          PH_BASE: begin
            base_q  <= wdata[7:IDX_W];
            phase_q <= PH_EXTRA;
          end
          PH_EXTRA: begin
            extra_q <= extra_q - 2'd1;
            if (extra_q <= 2'd1) phase_q <= PH_RUN;
          end
          default: mask_q <= wdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl
  import pic_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_unit,
  input  logic        reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] irq_lines,
  output logic        cpu_irq,
  output logic [7:0]  cpu_vector,
  input  logic        cpu_ack
);

  localparam int NUM_UNITS = 2;
  localparam int ALL_LINES = NUM_UNITS * LINES_PER_UNIT;
  localparam logic [LINES_PER_UNIT-1:0] CASC_BIT = LINES_PER_UNIT'(1) << CASCADE_LINE;

  logic [ALL_LINES-1:0]      all_rise;
  logic                      u_want [NUM_UNITS];
  logic [IDX_W-1:0]          u_pick [NUM_UNITS];
  logic [VEC_W-1:0]          u_vec  [NUM_UNITS];
  logic [LINES_PER_UNIT-1:0] u_mask [NUM_UNITS];
  logic [LINES_PER_UNIT-1:0] u_pend [NUM_UNITS];
  logic [LINES_PER_UNIT-1:0] u_serv [NUM_UNITS];
  logic                      u_init [NUM_UNITS];
  logic                      u_eoi  [NUM_UNITS];
  logic                      u_take [NUM_UNITS];

  // named internal events for the checker
  logic                      take_prim;
  logic                      take_sec;
  logic                      casc_win;
  logic [LINES_PER_UNIT-1:0] p_isr, s_isr, p_mask, s_mask;
  logic                      p_eoi, p_init;

  pic_edge_capture #(.WIDTH(ALL_LINES)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .rise  (all_rise)
  );

  assign casc_win  = (u_pick[0] == IDX_W'(CASCADE_LINE));
  assign take_prim = cpu_ack && cpu_irq;
  assign take_sec  = take_prim && casc_win;
  assign u_take[0] = take_prim;
  assign u_take[1] = take_sec;

  for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
    localparam logic [LINES_PER_UNIT-1:0] LVL = (gi == 0) ? CASC_BIT : '0;
    logic [LINES_PER_UNIT-1:0] lvl_in;
    logic                      sel_me;

    assign sel_me = reg_wr && (reg_unit == 1'(gi));
    if (gi == 0) begin : g_prim
      assign lvl_in = u_want[1] ? CASC_BIT : '0;
    end else begin : g_sec
      assign lvl_in = '0;
    end

    pic_unit #(.LEVEL_LINES(LVL)) u_pic (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (sel_me && !reg_sel),
      .data_we  (sel_me && reg_sel),
      .wdata    (reg_wdata),
      .rise     (all_rise[gi*LINES_PER_UNIT +: LINES_PER_UNIT]),
      .lvl      (lvl_in),
      .take     (u_take[gi]),
      .want     (u_want[gi]),
      .pick     (u_pick[gi]),
      .vec      (u_vec[gi]),
      .mask_q   (u_mask[gi]),
      .pend_q   (u_pend[gi]),
      .serv_q   (u_serv[gi]),
      .init_evt (u_init[gi]),
      .eoi_evt  (u_eoi[gi])
    );
  end

  assign cpu_irq    = u_want[0];
  assign cpu_vector = !cpu_irq ? '0 : (casc_win ? u_vec[1] : u_vec[0]);

  assign reg_rdata  = !reg_rd ? 8'h00 :
                      (reg_sel ? u_mask[reg_unit] : u_pend[reg_unit]);

  assign p_isr  = u_serv[0];
  assign s_isr  = u_serv[1];
  assign p_mask = u_mask[0];
  assign s_mask = u_mask[1];
  assign p_eoi  = u_eoi[0];
  assign p_init = u_init[0];

endmodule

// File: rtl/cascaded_irq_ctrl_checker.sv
module cascaded_irq_ctrl_checker #(
  parameter int CASCADE_LINE = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       cpu_irq,
  input logic       cpu_ack,
  input logic       take_sec,
  input logic [7:0] p_isr,
  input logic [7:0] s_isr,
  input logic [7:0] p_mask,
  input logic [7:0] s_mask,
  input logic       p_eoi,
  input logic       p_init
);

  assert_single_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_isr) && $onehot0(s_isr));

  assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> !cpu_irq);

  assert_cascade_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_sec |=> (p_isr[CASCADE_LINE] && ($countones(s_isr) == 1)));

  assert_service_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_ack && cpu_irq) && !p_eoi && !p_init) |=> $stable(p_isr));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(p_mask) && $stable(s_mask)));

endmodule

bind cascaded_irq_ctrl cascaded_irq_ctrl_checker #(.CASCADE_LINE(CASCADE_LINE)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .cpu_irq  (cpu_irq),
  .cpu_ack  (cpu_ack),
  .take_sec (take_sec),
  .p_isr    (p_isr),
  .s_isr    (s_isr),
  .p_mask   (p_mask),
  .s_mask   (s_mask),
  .p_eoi    (p_eoi),
  .p_init   (p_init)
);

// File: tb/test_cascaded_irq_ctrl.sv
module test_cascaded_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_unit = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] irq_lines = '0;
  logic        cpu_irq;
  logic [7:0]  cpu_vector;
  logic        mon_ack = 1'b0, man_ack = 1'b0, auto_ack = 1'b1;
  logic        cpu_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];

  localparam logic [7:0] PBASE = 8'h20;
  localparam logic [7:0] SBASE = 8'h28;

  assign cpu_ack = mon_ack | man_ack;

  always #2.5 clk = ~clk;

  cascaded_irq_ctrl i_cascaded_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_unit(reg_unit),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_ack(cpu_ack)
  );

  function automatic logic [7:0] vec_of(input int line);
    return (line < 8) ? PBASE + 8'(line) : SBASE + 8'(line - 8);
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic unit, input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_unit = unit; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic unit, input logic sel, output logic [7:0] d);
    reg_rd = 1'b1; reg_unit = unit; reg_sel = sel;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic check_reg(input string tag, input logic unit, input logic sel, input logic [7:0] exp);
    logic [7:0] v;
    rd(unit, sel, v);
    check8(tag, v, exp);
  endtask

  task automatic eoi(input logic unit);
    wr(unit, 1'b0, 8'h20);
  endtask

  task automatic pulse(input int line);
    irq_lines[line] = 1'b1;
    repeat (2) @(negedge clk);
    irq_lines[line] = 1'b0;
  endtask

  task automatic expect_line(input int line);
    exp_q.push_back(vec_of(line));
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: undelivered vectors actual=%0d expected=0", tag, exp_q.size());
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: compare offered vectors with the scoreboard, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && auto_ack && cpu_irq && !mon_ack) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected vector actual=%h expected=none", cpu_vector);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (cpu_vector !== e) begin
            errors++;
            $display("FAIL R2/R7: vector actual=%h expected=%h", cpu_vector, e);
          end
        end
        mon_ack = 1'b1;
        @(negedge clk);
        mon_ack = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check8("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);
    check_reg("R1 primary mask", 1'b0, 1'b1, 8'hFF);
    check_reg("R1 secondary mask", 1'b1, 1'b1, 8'hFF);
    check_reg("R1 primary pending", 1'b0, 1'b0, 8'h00);
    pulse(0);
    idle(4);
    check8("R1 no delivery before init", {7'd0, cpu_irq}, 8'h00);

    // R2/R4: initialisation (primary: two extra words, secondary: one)
    wr(1'b0, 1'b0, 8'h11); wr(1'b0, 1'b1, PBASE); wr(1'b0, 1'b1, 8'h04); wr(1'b0, 1'b1, 8'h01);
    wr(1'b1, 1'b0, 8'h10); wr(1'b1, 1'b1, SBASE); wr(1'b1, 1'b1, 8'h02);
    check_reg("R4 primary extra words ignored", 1'b0, 1'b1, 8'h00);
    check_reg("R4 secondary extra word ignored", 1'b1, 1'b1, 8'h00);
    wr(1'b1, 1'b1, 8'h40);
    check_reg("R4 next data write is mask", 1'b1, 1'b1, 8'h40);
    wr(1'b1, 1'b1, 8'h00);

    // R3: timer and keyboard lines deliver straight after init
    expect_line(0); pulse(0); drain("R3 timer line"); eoi(1'b0);
    expect_line(1); pulse(1); drain("R3 keyboard line"); eoi(1'b0);

    // R2: secondary mapping
    expect_line(13); pulse(13); drain("R2 secondary vector"); eoi(1'b1); eoi(1'b0);

    // R6/R7: masked lines stay pending; priority order 1, 8, 12, 3
    wr(1'b0, 1'b1, 8'hFF); wr(1'b1, 1'b1, 8'hFF);
    pulse(3); pulse(12); pulse(8); pulse(1); pulse(2);
    idle(3);
    check8("R6 masked no irq", {7'd0, cpu_irq}, 8'h00);
    check_reg("R6/R7 primary pending kept, slot 2 not a request", 1'b0, 1'b0, 8'h0A);
    check_reg("R6 secondary pending kept", 1'b1, 1'b0, 8'h11);
    expect_line(1);
    wr(1'b1, 1'b1, 8'h00); wr(1'b0, 1'b1, 8'h00);
    drain("R7 first line 1");
    expect_line(8);  eoi(1'b0); drain("R7 line 8 beats 3");
    expect_line(12); eoi(1'b1); eoi(1'b0); drain("R7 line 12 beats 3");
    expect_line(3);  eoi(1'b1); eoi(1'b0); drain("R7 line 3 last");
    eoi(1'b0);

    // R9: secondary line needs both EOIs
    expect_line(9); pulse(9); drain("R9 line 9");
    eoi(1'b1);
    pulse(10);
    idle(6);
    check8("R9 held after secondary-only EOI", {7'd0, cpu_irq}, 8'h00);
    expect_line(10); eoi(1'b0); drain("R9 released by primary EOI");
    eoi(1'b1); eoi(1'b0);

    // R10: primary mask bit 2 blocks the secondary
    wr(1'b0, 1'b1, 8'h04);
    pulse(11);
    idle(4);
    check8("R10 cascade masked", {7'd0, cpu_irq}, 8'h00);
    expect_line(5); pulse(5); drain("R10 primary line still works"); eoi(1'b0);
    expect_line(11); wr(1'b0, 1'b1, 8'h00); drain("R10 unmask delivers 11");
    eoi(1'b1); eoi(1'b0);

    // R8: nothing new while in service
    expect_line(0); pulse(0); drain("R8 line 0");
    pulse(4);
    idle(6);
    check8("R8 blocked until EOI", {7'd0, cpu_irq}, 8'h00);
    check_reg("R8 new edge pending", 1'b0, 1'b0, 8'h10);
    expect_line(4); eoi(1'b0); drain("R8 after EOI"); eoi(1'b0);

    // R5: held-high line gives one request
    expect_line(6); irq_lines[6] = 1'b1; drain("R5 held line once"); eoi(1'b0);
    idle(8);
    check_reg("R5 no second request", 1'b0, 1'b0, 8'h00);
    irq_lines[6] = 1'b0;
    idle(2);

    // R12: acknowledge without request
    wr(1'b0, 1'b1, 8'h80);
    pulse(7);
    idle(2);
    check_reg("R12 pending before stray ack", 1'b0, 1'b0, 8'h80);
    man_ack = 1'b1; @(negedge clk); man_ack = 1'b0;
    check_reg("R12 pending after stray ack", 1'b0, 1'b0, 8'h80);
    expect_line(7); wr(1'b0, 1'b1, 8'h00); drain("R12 line 7 delivered"); eoi(1'b0);

    // R11: new edge and acknowledge in the same cycle
    auto_ack = 1'b0;
    pulse(5);
    @(negedge clk);
    check8("R11 vector before ack", cpu_vector, vec_of(5));
    man_ack = 1'b1; irq_lines[5] = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    check8("R11 irq drops after ack", {7'd0, cpu_irq}, 8'h00);
    check_reg("R11 line stays pending", 1'b0, 1'b0, 8'h20);
    irq_lines[5] = 1'b0;
    auto_ack = 1'b1;
    expect_line(5); eoi(1'b0); drain("R11 redelivered"); eoi(1'b0);

    // R13: read strobe low gives zero
    #1 check8("R13 idle read data", reg_rdata, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule